// File: doc/BRIEF.md
# Swizzling Copy Engine

This block moves bytes from one region of memory to another after a single launch pulse. The caller supplies the source and destination offsets, a pitch for each side, a line length and a line count on inputs that are captured at launch. In rectangle mode the engine copies a two-dimensional region line by line, and each side steps by its own pitch. In run mode it copies one run of bytes. A run can be a fill with a 32-bit constant, a straight copy, or a copy that reorders address bits 4 to 8 on whichever side is stored in block-linear form.

In run mode, the engine decides whether each side is pitch or block-linear by asking a page-kind lookup port about the source offset and then about the destination offset. All memory traffic uses a byte-wide read channel and a byte-wide write channel, each with a valid/ready handshake. At most one access is outstanding at a time. When a launch finishes, the engine raises a one-cycle semaphore pulse.

Top module: `cpe_copy_engine`

## Requirements
- R1: After reset, busy_o, sem_o, rd_valid_o and wr_valid_o are all low.
- R2: In rectangle mode (multi_i=1), for each line n below lines_i and each byte i below len_i, the byte at src_off_i + n*src_pitch_i + i is written to dst_off_i + n*dst_pitch_i + i.
- R3: A rectangle-mode launch with src_blk_i=1 and dst_blk_i=1 is rejected. It makes no memory request and gives no semaphore pulse, and busy_o stays low.
- R4: In run mode with remap_en_i=1 and dst_x_sel_i equal to 3'd4 (constant A), the engine writes len_i*4 bytes starting at dst_off_i. Byte k is fill_val_i[8*(k mod 4) +: 8], so each word is little-endian. No read is issued.
- R5: In a run-mode copy, the kind of src_off_i is looked up through kind_addr_o first and the kind of dst_off_i second, with kind_i returned in the same cycle. A kind of 8'h00 or 8'hFD means pitch; every other value means block-linear.
- R6: If the source is block-linear and the destination is pitch, byte i goes to dst_off_i+i and is read from swz(src_off_i+i). swz keeps every bit except bits 4 to 8, and sets new bit 4 to old bit 6, new bit 5 to old bit 4, new bits 7:6 to old bits 8:7, and new bit 8 to old bit 5.
- R7: If the source is pitch and the destination is block-linear, byte i is read from src_off_i+i and written to swz(dst_off_i+i).
- R8: If both sides have the same class, byte i is copied from src_off_i+i to dst_off_i+i.
- R9: busy_o goes high in the cycle after an accepted launch and stays high up to and including the single cycle in which sem_o pulses. Busy falls in the following cycle. A launch that moves zero bytes still gives the pulse.
- R10: A launch_i pulse while busy_o is high is ignored. The current transfer and its memory contents are unchanged, and no extra pulse follows.
- R11: rd_valid_o and wr_valid_o are never high together, and a request holds its address and data stable until it is accepted.
- R12: In run mode, remap_en_i=1 with any dst_x_sel_i other than 3'd4 performs a kind-based copy (R5 to R8), not a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start pulse |
| multi_i | input | 1 | 1 selects rectangle mode, 0 selects run mode |
| src_blk_i | input | 1 | Source layout is block-linear (rectangle mode) |
| dst_blk_i | input | 1 | Destination layout is block-linear (rectangle mode) |
| remap_en_i | input | 1 | Remap enable |
| dst_x_sel_i | input | 3 | Destination X component select; 3'd4 is constant A |
| fill_val_i | input | 32 | Fill constant |
| src_off_i | input | AW | Source offset |
| dst_off_i | input | AW | Destination offset |
| src_pitch_i | input | AW | Source pitch |
| dst_pitch_i | input | AW | Destination pitch |
| len_i | input | LW | Bytes per line, or words for a fill |
| lines_i | input | CW | Line count (rectangle mode) |
| kind_addr_o | output | AW | Page-kind lookup address |
| kind_i | input | 8 | Page kind for kind_addr_o |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 8 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 8 | Write data |
| busy_o | output | 1 | Transfer in progress |
| sem_o | output | 1 | Completion pulse |

## Verification
The assertions check the channel rules on every cycle: a read and a write are never requested together, and each request holds its address and data until it is taken. They also check that a fill never issues a read, that the completion pulse lasts one cycle and is followed by idle, and that the byte counter stays below the line length. Only the bench scenarios can show the data results. These are the placement of rectangle lines, the bit swap on the block-linear side, how the page-kind classes are decoded, the rejection of a launch with both sides block-linear, and the dropping of a launch that arrives while busy. The bench shows these by comparing the whole memory image with a model and by counting reads, writes and pulses.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam logic [7:0] KIND_PITCH     = 8'h00;
  localparam logic [7:0] KIND_PITCH_RAW = 8'hFD;
  localparam logic [2:0] SEL_CONST_A    = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_KSRC, S_KDST, S_RD, S_RSP, S_WR, S_SEM
  } cpe_state_e;
endpackage

// File: rtl/cpe_swizzle.sv
module cpe_swizzle #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a_i,
  output logic [AW-1:0] a_o
);
  assign a_o = {a_i[AW-1:9], a_i[5], a_i[8:7], a_i[4], a_i[6], a_i[3:0]};
endmodule

// File: rtl/cpe_kind_class.sv
module cpe_kind_class
  import cpe_pkg::*;
(
  input  logic [7:0] kind_i,
  output logic       is_pitch_o
);
  assign is_pitch_o = (kind_i == KIND_PITCH) || (kind_i == KIND_PITCH_RAW);
endmodule

// File: rtl/cpe_addr_gen.sv
module cpe_addr_gen #(
  parameter int AW = 32,
  parameter int BW = 18,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] src_pitch_i,
  input  logic [AW-1:0] dst_pitch_i,
  input  logic [BW-1:0] bpl_i,
  input  logic [CW-1:0] lines_i,
  input  logic          src_swz_i,
  input  logic          dst_swz_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [1:0]    byte_lo_o,
  output logic          last_o
);
  logic [AW-1:0] src_line_q, dst_line_q, src_lin, dst_lin, src_sw, dst_sw;
  logic [AW-1:0] sp_q, dp_q;
  logic [BW-1:0] byte_q;
  logic [CW-1:0] line_q;
  logic          last_byte;

  assign src_lin = src_line_q + AW'(byte_q);
  assign dst_lin = dst_line_q + AW'(byte_q);

  cpe_swizzle #(.AW(AW)) u_swz_src (.a_i(src_lin), .a_o(src_sw));
  cpe_swizzle #(.AW(AW)) u_swz_dst (.a_i(dst_lin), .a_o(dst_sw));

  assign rd_addr_o = src_swz_i ? src_sw : src_lin;
  assign wr_addr_o = dst_swz_i ? dst_sw : dst_lin;
  assign byte_lo_o = byte_q[1:0];
  assign last_byte = (byte_q == bpl_i - BW'(1));
  assign last_o    = last_byte && (line_q == lines_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_line_q <= '0;
      dst_line_q <= '0;
      sp_q       <= '0;
      dp_q       <= '0;
      byte_q     <= '0;
      line_q     <= '0;
    end else if (load_i) begin
      src_line_q <= src_base_i;
      dst_line_q <= dst_base_i;
      sp_q       <= src_pitch_i;
      dp_q       <= dst_pitch_i;
      byte_q     <= '0;
      line_q     <= '0;
    end else if (step_i) begin
      if (last_byte) begin
        byte_q     <= '0;
        line_q     <= line_q + CW'(1);
        src_line_q <= src_line_q + sp_q;
        dst_line_q <= dst_line_q + dp_q;
      end else begin
        byte_q <= byte_q + BW'(1);
      end
    end
  end

  p_byte_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (byte_q < bpl_i));
endmodule

// File: rtl/cpe_copy_engine.sv
module cpe_copy_engine
  import cpe_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          multi_i,
  input  logic          src_blk_i,
  input  logic          dst_blk_i,
  input  logic          remap_en_i,
  input  logic [2:0]    dst_x_sel_i,
  input  logic [31:0]   fill_val_i,
  input  logic [AW-1:0] src_off_i,
  input  logic [AW-1:0] dst_off_i,
  input  logic [AW-1:0] src_pitch_i,
  input  logic [AW-1:0] dst_pitch_i,
  input  logic [LW-1:0] len_i,
  input  logic [CW-1:0] lines_i,
  output logic [AW-1:0] kind_addr_o,
  input  logic [7:0]    kind_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rsp_valid_i,
  input  logic [7:0]    rsp_data_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          busy_o,
  output logic          sem_o
);
  localparam int BW = LW + 2;

  cpe_state_e    state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [BW-1:0] bpl_q, bpl_n;
  logic [CW-1:0] lines_q, lines_n;
  logic [31:0]   fv_q;
  logic [7:0]    data_q;
  logic          fill_q, src_swz_q, dst_swz_q, src_pitch_q;
  logic          fill_n, reject_n, empty_n, start, step, last, kind_pitch;
  logic [1:0]    byte_lo;

  assign fill_n   = !multi_i && remap_en_i && (dst_x_sel_i == SEL_CONST_A);
  assign reject_n = multi_i && src_blk_i && dst_blk_i;
  assign bpl_n    = fill_n ? {len_i, 2'b00} : {2'b00, len_i};
  assign lines_n  = multi_i ? lines_i : CW'(1);
  assign empty_n  = (len_i == '0) || (lines_n == '0);
  assign start    = (state_q == S_IDLE) && launch_i && !reject_n;
  assign step     = (state_q == S_WR) && wr_ready_i;

  cpe_kind_class u_kind (.kind_i(kind_i), .is_pitch_o(kind_pitch));

  cpe_addr_gen #(.AW(AW), .BW(BW), .CW(CW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .step_i      (step),
    .src_base_i  (src_off_i),
    .dst_base_i  (dst_off_i),
    .src_pitch_i (src_pitch_i),
    .dst_pitch_i (dst_pitch_i),
    .bpl_i       (bpl_q),
    .lines_i     (lines_q),
    .src_swz_i   (src_swz_q),
    .dst_swz_i   (dst_swz_q),
    .rd_addr_o   (rd_addr_o),
    .wr_addr_o   (wr_addr_o),
    .byte_lo_o   (byte_lo),
    .last_o      (last)
  );

  assign kind_addr_o = (state_q == S_KSRC) ? src_q : dst_q;
  assign rd_valid_o  = (state_q == S_RD);
  assign wr_valid_o  = (state_q == S_WR);
  assign wr_data_o   = fill_q ? fv_q[{byte_lo, 3'b000} +: 8] : data_q;
  assign busy_o      = (state_q != S_IDLE);
  assign sem_o       = (state_q == S_SEM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      src_q       <= '0;
      dst_q       <= '0;
      bpl_q       <= '0;
      lines_q     <= '0;
      fv_q        <= '0;
      data_q      <= '0;
      fill_q      <= 1'b0;
      src_swz_q   <= 1'b0;
      dst_swz_q   <= 1'b0;
      src_pitch_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          src_q     <= src_off_i;
          dst_q     <= dst_off_i;
          bpl_q     <= bpl_n;
          lines_q   <= lines_n;
          fv_q      <= fill_val_i;
          fill_q    <= fill_n;
          src_swz_q <= 1'b0;
          dst_swz_q <= 1'b0;
          if (multi_i)     state_q <= empty_n ? S_SEM : S_RD;
          else if (fill_n) state_q <= empty_n ? S_SEM : S_WR;
          else             state_q <= S_KSRC;
        end
        S_KSRC: begin
          src_pitch_q <= kind_pitch;
          state_q     <= S_KDST;
        end
        S_KDST: begin
          src_swz_q <= !src_pitch_q && kind_pitch;
          dst_swz_q <= src_pitch_q && !kind_pitch;
          state_q   <= (bpl_q == '0) ? S_SEM : S_RD;
        end
        S_RD:  if (rd_ready_i) state_q <= S_RSP;
        S_RSP: if (rsp_valid_i) begin
          data_q  <= rsp_data_i;
          state_q <= S_WR;
        end
        S_WR: if (wr_ready_i) begin
          if (last)        state_q <= S_SEM;
          else if (fill_q) state_q <= S_WR;
          else             state_q <= S_RD;
        end
        S_SEM:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_one_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));
  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  p_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  p_sem_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_o |=> !sem_o && !busy_o);
  p_fill_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q && busy_o |-> !rd_valid_o);
endmodule

// File: tb/cpe_copy_engine_tb.sv
module cpe_copy_engine_tb;
  localparam int AW = 32, LW = 16, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          launch = 0, multi = 0, sblk = 0, dblk = 0, remap = 0;
  logic [2:0]    sel = 0;
  logic [31:0]   fval = 0;
  logic [AW-1:0] soff = 0, doff = 0, sp = 0, dp = 0;
  logic [LW-1:0] len = 0;
  logic [CW-1:0] lines = 0;
  logic [AW-1:0] kind_addr, rd_addr, wr_addr;
  logic [7:0]    kind, rsp_data = 0, wr_data;
  logic          rd_valid, rd_ready = 0, rsp_valid = 0, wr_valid, wr_ready = 0, busy, sem;

  logic [7:0] mem [4096];
  logic [7:0] expm [4096];
  logic [7:0] kinds [4];
  assign kind = kinds[kind_addr[11:10]];

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0, sem_cnt = 0, cyc = 0;
  logic          pend = 0;
  logic [AW-1:0] paddr = 0;

  cpe_copy_engine #(.AW(AW), .LW(LW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .multi_i(multi),
    .src_blk_i(sblk), .dst_blk_i(dblk), .remap_en_i(remap), .dst_x_sel_i(sel),
    .fill_val_i(fval), .src_off_i(soff), .dst_off_i(doff), .src_pitch_i(sp),
    .dst_pitch_i(dp), .len_i(len), .lines_i(lines), .kind_addr_o(kind_addr),
    .kind_i(kind), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .sem_o(sem)
  );

  // memory and kind model with random backpressure
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sem) sem_cnt <= sem_cnt + 1;
    rd_ready  <= ($urandom % 3) != 0;
    wr_ready  <= ($urandom % 3) != 0;
    rsp_valid <= 1'b0;
    if (pend && ($urandom % 2) == 0) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[paddr[11:0]];
      pend      <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      pend   <= 1'b1;
      paddr  <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (wr_valid && wr_ready) begin
      mem[wr_addr[11:0]] = wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    fails = fails + 1;
    $display("FAIL watchdog: act=%0d exp<190000 cycles", cyc);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] swz(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a & ~AW'(32'h1F0);
    r[4] = a[6]; r[5] = a[4]; r[6] = a[7]; r[7] = a[8]; r[8] = a[5];
    return r;
  endfunction

  function automatic bit is_pitch(input logic [7:0] k);
    return (k == 8'h00) || (k == 8'hFD);
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, "memory image", 0, 0);
    else chk(1'b0, req, $sformatf("memory @%0h", first), mem[first], expm[first]);
  endtask

  // builds expected image, launches, waits, checks
  task automatic run_op(input string req, input bit m, input bit sb, input bit db,
                        input bit re, input logic [2:0] xs, input logic [31:0] fv,
                        input int s, input int d, input int spi, input int dpi,
                        input int ln, input int nl);
    int exp_rd, exp_wr, exp_sem, rd0, wr0, sem0, t;
    bit rej, fl, spc, dpc;
    logic [AW-1:0] ra, wa;
    for (int i = 0; i < 4096; i++) expm[i] = mem[i];
    rej = m && sb && db;
    fl  = !m && re && (xs == 3'd4);
    exp_rd = 0; exp_wr = 0; exp_sem = rej ? 0 : 1;
    if (rej) begin
    end else if (m) begin
      for (int n = 0; n < nl; n++)
        for (int i = 0; i < ln; i++)
          expm[(d + n*dpi + i) % 4096] = expm[(s + n*spi + i) % 4096];
      exp_rd = ln * nl; exp_wr = ln * nl;
    end else if (fl) begin
      for (int k = 0; k < ln*4; k++) expm[(d + k) % 4096] = fv[8*(k%4) +: 8];
      exp_wr = ln * 4;
    end else begin
      spc = is_pitch(kinds[(s >> 10) & 3]);
      dpc = is_pitch(kinds[(d >> 10) & 3]);
      for (int i = 0; i < ln; i++) begin
        ra = (!spc && dpc) ? swz(AW'(s + i)) : AW'(s + i);
        wa = (spc && !dpc) ? swz(AW'(d + i)) : AW'(d + i);
        expm[wa[11:0]] = expm[ra[11:0]];
      end
      exp_rd = ln; exp_wr = ln;
    end
    @(negedge clk);
    multi = m; sblk = sb; dblk = db; remap = re; sel = xs; fval = fv;
    soff = AW'(s); doff = AW'(d); sp = AW'(spi); dp = AW'(dpi);
    len = LW'(ln); lines = CW'(nl);
    rd0 = rd_cnt; wr0 = wr_cnt; sem0 = sem_cnt;
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    chk(busy == !rej, rej ? "R3" : "R9", "busy after launch", busy, !rej);
    if (rej) repeat (20) @(negedge clk);
    else begin
      t = 0;
      while (sem_cnt == sem0 && t < 20000) begin @(negedge clk); t++; end
      chk(busy == 1'b0, "R9", "busy after pulse", busy, 0);
      repeat (3) @(negedge clk);
    end
    check_mem(req);
    chk(sem_cnt - sem0 == exp_sem, rej ? "R3" : "R9", "semaphore pulses", sem_cnt - sem0, exp_sem);
    chk(rd_cnt - rd0 == exp_rd, req, "read count", rd_cnt - rd0, exp_rd);
    chk(wr_cnt - wr0 == exp_wr, req, "write count", wr_cnt - wr0, exp_wr);
  endtask

  initial begin
    int wr0, sem0, t;
    logic [7:0] pk [5];
    void'($urandom(32'd1357));
    pk[0] = 8'h00; pk[1] = 8'hFD; pk[2] = 8'hFE; pk[3] = 8'hFF; pk[4] = 8'h11;
    for (int i = 0; i < 4; i++) kinds[i] = 8'h00;
    fill_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !sem && !rd_valid && !wr_valid, "R1", "reset outputs",
        {busy, sem, rd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R2", 1, 0, 0, 0, 0, 0, 16, 2100, 40, 24, 12, 4);
    run_op("R2", 1, 1, 0, 0, 0, 0, 5, 2300, 9, 17, 7, 3);
    run_op("R3", 1, 1, 1, 0, 0, 0, 0, 2048, 8, 8, 8, 2);
    run_op("R4", 0, 0, 0, 1, 3'd4, 32'hA1B2C3D4, 0, 2050, 0, 0, 5, 0);
    run_op("R9", 1, 0, 0, 0, 0, 0, 0, 2048, 8, 8, 0, 3);
    run_op("R9", 0, 0, 0, 1, 3'd4, 32'h1, 0, 2048, 0, 0, 0, 0);
    kinds[0] = 8'hFF; kinds[2] = 8'h00;
    run_op("R6", 0, 0, 0, 0, 0, 0, 512, 2560, 0, 0, 96, 0);
    kinds[0] = 8'hFD; kinds[2] = 8'h11;
    run_op("R7", 0, 0, 0, 0, 0, 0, 0, 2048, 0, 0, 128, 0);
    kinds[0] = 8'hFE; kinds[2] = 8'h11;
    run_op("R8", 0, 0, 0, 0, 0, 0, 100, 2200, 0, 0, 33, 0);
    kinds[0] = 8'h00; kinds[2] = 8'hFD;
    run_op("R5", 0, 0, 0, 0, 0, 0, 40, 2400, 0, 0, 20, 0);
    kinds[0] = 8'hFF; kinds[2] = 8'h00;
    run_op("R12", 0, 0, 0, 1, 3'd1, 32'hDEADBEEF, 16, 2080, 0, 0, 48, 0);

    // R10: launch while busy is dropped
    for (int i = 0; i < 4096; i++) expm[i] = mem[i];
    for (int n = 0; n < 3; n++)
      for (int i = 0; i < 8; i++) expm[2600 + n*16 + i] = expm[64 + n*12 + i];
    @(negedge clk);
    multi = 1; sblk = 0; dblk = 0; remap = 0; sel = 0;
    soff = 64; doff = 2600; sp = 12; dp = 16; len = 8; lines = 3;
    wr0 = wr_cnt; sem0 = sem_cnt;
    launch = 1; @(negedge clk); launch = 0;
    repeat (5) @(negedge clk);
    multi = 0; remap = 1; sel = 3'd4; fval = 32'h55AA55AA; doff = 2600; len = 8;
    launch = 1; @(negedge clk); launch = 0;
    t = 0;
    while (sem_cnt == sem0 && t < 20000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    check_mem("R10");
    chk(sem_cnt - sem0 == 1, "R10", "pulses", sem_cnt - sem0, 1);
    chk(wr_cnt - wr0 == 24, "R10", "writes", wr_cnt - wr0, 24);

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      int mode, ln;
      mode = $urandom % 3;
      kinds[0] = pk[$urandom % 5];
      kinds[2] = pk[$urandom % 5];
      if (mode == 0) begin
        ln = $urandom % 65;
        run_op("R2", 1, 1'($urandom), 0, 0, 0, 0, $urandom % 256, 2048 + $urandom % 256,
               ln + $urandom % 32, ln + $urandom % 32, ln, 1 + $urandom % 6);
      end else if (mode == 1) begin
        run_op("R4", 0, 0, 0, 1, 3'd4, $urandom, 0, 2048 + $urandom % 256, 0, 0,
               $urandom % 17, 0);
      end else begin
        run_op("R5", 0, 0, 0, 1'($urandom), 3'($urandom % 4), 0, $urandom % 900,
               2048 + $urandom % 900, 0, 0, $urandom % 65, 0);
      end
    end
    summary();
    $finish;
  end
endmodule